// File: doc/BRIEF.md
# Interrupt Priority Tracker

This block keeps the interrupt state of one processor for 256 vectors. It holds three bit arrays: one marks the vectors waiting for service, one marks the vectors being serviced, and one records whether each vector arrived level or edge triggered. A task priority value is written from outside. The block derives the processor priority from the task priority and the highest vector in service. It then tells the core, in the same cycle, whether a vector can be delivered and which one.

The core takes the offered vector with an acknowledge strobe, which moves it from waiting to in service. When the handler ends, an end-of-service strobe retires the highest vector in service. In that same cycle the block reports the retired vector and its trigger mode, so a level-triggered source can be re-armed. A request port accepts new vectors. It reports whether each request was recorded or merged into one that is already waiting. Requests are dropped while either enable input is low.

Top module: `intr_prio_tracker`

## Requirements
- R1: A request with req_valid high, both enables high, a vector of 16 or above and that vector not already waiting raises req_accepted in the same cycle. The vector is waiting from the next cycle.
- R2: A request for a vector that is already waiting gives req_accepted low and changes no state (coalesced).
- R3: A request is dropped, with req_accepted low and no state change, when hw_en or sw_en is low or when the vector is below 16.
- R4: An accepted request with req_level high records the vector as level triggered, and one with req_level low records it as edge triggered. The recorded mode appears on eoi_level when that vector is retired.
- R5: ppr equals the task priority when bits 7:4 of the task priority are at least bits 7:4 of the highest vector in service, where an empty in-service set counts as vector 0. Otherwise ppr equals that vector with bits 3:0 cleared.
- R6: irq_pending is high exactly when both enables are high, some vector is waiting, and the highest waiting vector with bits 3:0 cleared is strictly greater than ppr. irq_vector then gives that highest waiting vector.
- R7: ack while irq_pending is high makes irq_vector in service and no longer waiting from the next cycle. ack while irq_pending is low has no effect.
- R8: eoi with at least one vector in service raises eoi_valid in the same cycle and gives the highest in-service vector on eoi_vector. That vector leaves service from the next cycle. eoi with nothing in service gives eoi_valid low and changes no state.
- R9: ack and eoi in the same cycle both take effect. The acknowledged vector enters service and the previous highest in-service vector is retired. A task priority write takes effect on ppr in the next cycle.
- R10: After reset nothing is waiting or in service, the task priority is 0, ppr is 0 and irq_pending is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | Request is level triggered |
| req_accepted | output | 1 | Request recorded this cycle |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| ack | input | 1 | Core takes the offered vector |
| eoi | input | 1 | End of service strobe |
| irq_pending | output | 1 | A vector is deliverable |
| irq_vector | output | 8 | Deliverable vector |
| ppr | output | 8 | Processor priority |
| eoi_valid | output | 1 | A vector was retired this cycle |
| eoi_vector | output | 8 | Retired vector |
| eoi_level | output | 1 | Retired vector was level triggered |

## Verification
Acknowledge and end-of-service can both fire in one cycle. One of them then adds an in-service vector while the other removes the previous top one, and the processor priority must follow both. The stimulus reaches this case on purpose, by acknowledging a higher-class vector while a lower one is still in service and strobing eoi at the same time. Random traffic also reaches it often. Both cases are judged against a behavioural model that applies the two updates in order and checks the retired vector, its trigger mode, the next offered vector and ppr on every clock. A request can also arrive in the same cycle as a retire of the same vector. In that case the request's trigger mode must be the one that remains recorded.

// File: rtl/intr_tracker_pkg.sv
`timescale 1ns/1ps
package intr_tracker_pkg;
    localparam int DEF_VEC_W   = 8;   // vector index width (256 vectors)
    localparam int DEF_WORD_W  = 32;  // bits per scan word
    localparam int DEF_MIN_VEC = 16;  // lowest vector that may be recorded
    localparam int DEF_CLASS_W = 4;   // upper bits that form the priority class
endpackage

// File: rtl/bit_scan.sv
`timescale 1ns/1ps
// Returns the index of the highest set bit of a vector.
module bit_scan #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (bits[i]) idx = IW'(i);
        end
    end
    assign found = |bits;
endmodule

// File: rtl/vec_scan.sv
`timescale 1ns/1ps
// Two-level highest-set-bit search: per-word scans, then a scan over word flags.
module vec_scan #(
    parameter int VEC_W  = 8,
    parameter int WORD_W = 32
) (
    input  logic [(1<<VEC_W)-1:0] bits,
    output logic                  found,
    output logic [VEC_W-1:0]      top
);
    localparam int NUM_VEC   = 1 << VEC_W;
    localparam int NUM_WORDS = NUM_VEC / WORD_W;
    localparam int BIT_IW    = $clog2(WORD_W);
    localparam int WORD_IW   = $clog2(NUM_WORDS);

    logic [NUM_WORDS-1:0] word_any;
    logic [BIT_IW-1:0]    word_idx [NUM_WORDS];
    logic [WORD_IW-1:0]   top_word;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        bit_scan #(.W(WORD_W), .IW(BIT_IW)) u_word (
            .bits  (bits[w*WORD_W +: WORD_W]),
            .found (word_any[w]),
            .idx   (word_idx[w])
        );
    end

    bit_scan #(.W(NUM_WORDS), .IW(WORD_IW)) u_words (
        .bits  (word_any),
        .found (found),
        .idx   (top_word)
    );

    assign top = {top_word, word_idx[top_word]};
endmodule

// File: rtl/ppr_unit.sv
`timescale 1ns/1ps
// Derives processor priority from task priority and the top in-service vector.
module ppr_unit #(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_found,
    input  logic [VEC_W-1:0] isr_top,
    output logic [VEC_W-1:0] ppr
);
    localparam int SUB_W = VEC_W - CLASS_W;

    logic [VEC_W-1:0] isr_eff;

    always_comb begin
        isr_eff = isr_found ? isr_top : '0;
        if (tpr[VEC_W-1 -: CLASS_W] >= isr_eff[VEC_W-1 -: CLASS_W]) begin
            ppr = tpr;
        end else begin
            ppr = {isr_eff[VEC_W-1 -: CLASS_W], {SUB_W{1'b0}}};
        end
    end
endmodule

// File: rtl/intr_prio_tracker.sv
`timescale 1ns/1ps
module intr_prio_tracker
    import intr_tracker_pkg::*;
#(
    parameter int VEC_W   = DEF_VEC_W,
    parameter int WORD_W  = DEF_WORD_W,
    parameter int MIN_VEC = DEF_MIN_VEC,
    parameter int CLASS_W = DEF_CLASS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_en,
    input  logic             sw_en,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic             req_level,
    output logic             req_accepted,
    input  logic             tpr_we,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             ack,
    input  logic             eoi,
    output logic             irq_pending,
    output logic [VEC_W-1:0] irq_vector,
    output logic [VEC_W-1:0] ppr,
    output logic             eoi_valid,
    output logic [VEC_W-1:0] eoi_vector,
    output logic             eoi_level
);
    localparam int NUM_VEC = 1 << VEC_W;
    localparam logic [VEC_W-1:0] CLASS_MASK = {{CLASS_W{1'b1}}, {(VEC_W-CLASS_W){1'b0}}};
    localparam logic [VEC_W-1:0] MIN_V = VEC_W'(MIN_VEC);

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;   // waiting
        logic [NUM_VEC-1:0] isr;   // in service
        logic [NUM_VEC-1:0] tmr;   // 1 = level triggered
        logic [VEC_W-1:0]   tpr;   // task priority
    } trk_state_t;

    trk_state_t st_q, st_d;

    logic             irr_found, isr_found;
    logic [VEC_W-1:0] irr_top, isr_top, ppr_val;
    logic             unit_en, deliver, ack_fire, eoi_fire, take_req;

    vec_scan #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_irr_scan (
        .bits  (st_q.irr),
        .found (irr_found),
        .top   (irr_top)
    );

    vec_scan #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_isr_scan (
        .bits  (st_q.isr),
        .found (isr_found),
        .top   (isr_top)
    );

    ppr_unit #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_ppr (
        .tpr       (st_q.tpr),
        .isr_found (isr_found),
        .isr_top   (isr_top),
        .ppr       (ppr_val)
    );

    assign unit_en  = hw_en & sw_en;
    assign deliver  = unit_en & irr_found & ((irr_top & CLASS_MASK) > ppr_val);
    assign ack_fire = ack & deliver;
    assign eoi_fire = eoi & isr_found;
    assign take_req = req_valid & unit_en & (req_vector >= MIN_V) & ~st_q.irr[req_vector];

    // Next state: acknowledge, then retire, then request, then task priority.
    always_comb begin
        st_d = st_q;
        if (ack_fire) begin
            st_d.isr[irr_top] = 1'b1;
            st_d.irr[irr_top] = 1'b0;
        end
        if (eoi_fire) begin
            st_d.isr[isr_top] = 1'b0;
            st_d.tmr[isr_top] = 1'b0;
        end
        if (take_req) begin
            st_d.irr[req_vector] = 1'b1;
            st_d.tmr[req_vector] = req_level;
        end
        if (tpr_we) begin
            st_d.tpr = tpr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_accepted = take_req;
    assign irq_pending  = deliver;
    assign irq_vector   = irr_found ? irr_top : '0;
    assign ppr          = ppr_val;
    assign eoi_valid    = eoi_fire;
    assign eoi_vector   = eoi_fire ? isr_top : '0;
    assign eoi_level    = eoi_fire & st_q.tmr[isr_top];

    AST_ACCEPT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        req_accepted |=> st_q.irr[$past(req_vector)]); // R1
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_en && sw_en) |=> $stable(st_q.irr)); // R3
    AST_MODE_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        req_accepted |=> st_q.tmr[$past(req_vector)] == $past(req_level)); // R4
    AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= st_q.tpr); // R5
    AST_OFFER_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> st_q.irr[irq_vector] && !st_q.isr[irq_vector]); // R6
    AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        ack && irq_pending |=> st_q.isr[$past(irq_vector)] && !st_q.irr[$past(irq_vector)]); // R7
    AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |=> !st_q.isr[$past(eoi_vector)]); // R8
endmodule

// File: tb/intr_prio_tracker_test.sv
`timescale 1ns/1ps
module intr_prio_tracker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b0, sw_en = 1'b0;
    logic       req_valid = 1'b0, req_level = 1'b0;
    logic [7:0] req_vector = '0;
    logic       req_accepted;
    logic       tpr_we = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       ack = 1'b0, eoi = 1'b0;
    logic       irq_pending, eoi_valid, eoi_level;
    logic [7:0] irq_vector, ppr, eoi_vector;

    int errors = 0;
    int checks = 0;

    // Behavioural reference state
    logic [255:0] m_irr, m_isr, m_tmr;
    logic [7:0]   m_tpr;
    logic         x_acc, x_pend, x_eoiv, x_eoil;
    logic [7:0]   x_vec, x_ppr, x_eoivec;

    always #2.5 clk = ~clk;

    intr_prio_tracker uut (
        .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
        .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
        .req_accepted(req_accepted), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .ack(ack), .eoi(eoi), .irq_pending(irq_pending), .irq_vector(irq_vector),
        .ppr(ppr), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level)
    );

    function automatic int top_of(input logic [255:0] a);
        for (int i = 255; i >= 0; i--) if (a[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_eval();
        int hi_irr, hi_isr, isrv;
        hi_irr = top_of(m_irr);
        hi_isr = top_of(m_isr);
        isrv = (hi_isr < 0) ? 0 : hi_isr;
        x_ppr = ((m_tpr / 16) >= (isrv / 16)) ? m_tpr : 8'((isrv / 16) * 16);
        x_pend = hw_en && sw_en && hi_irr >= 0 && ((hi_irr / 16) * 16) > int'(x_ppr);
        x_vec = 8'((hi_irr < 0) ? 0 : hi_irr);
        x_acc = req_valid && hw_en && sw_en && req_vector >= 16 && !m_irr[req_vector];
        x_eoiv = eoi && hi_isr >= 0;
        x_eoivec = 8'(isrv);
        x_eoil = x_eoiv && m_tmr[isrv];
    endtask

    task automatic drive(input logic rv, input int vec, input logic lvl,
                         input logic tw, input int td, input logic a, input logic e,
                         input logic hw, input logic sw);
        @(negedge clk);
        req_valid = rv; req_vector = 8'(vec); req_level = lvl;
        tpr_we = tw; tpr_wdata = 8'(td); ack = a; eoi = e; hw_en = hw; sw_en = sw;
        #2;
        model_eval();
        chk("R1/R2/R3", "req_accepted", req_accepted, x_acc);
        chk("R6", "irq_pending", irq_pending, x_pend);
        if (x_pend) chk("R6", "irq_vector", irq_vector, x_vec);
        chk("R5", "ppr", ppr, x_ppr);
        chk("R8", "eoi_valid", eoi_valid, x_eoiv);
        if (x_eoiv) begin
            chk("R8", "eoi_vector", eoi_vector, x_eoivec);
            chk("R4", "eoi_level", eoi_level, x_eoil);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (x_pend && ack) begin m_isr[x_vec] = 1'b1; m_irr[x_vec] = 1'b0; end
        if (x_eoiv) begin m_isr[x_eoivec] = 1'b0; m_tmr[x_eoivec] = 1'b0; end
        if (x_acc) begin m_irr[req_vector] = 1'b1; m_tmr[req_vector] = req_level; end
        if (tpr_we) m_tpr = tpr_wdata;
    endtask

    task automatic step(input logic rv, input int vec, input logic lvl,
                        input logic tw, input int td, input logic a, input logic e);
        drive(rv, vec, lvl, tw, td, a, e, 1'b1, 1'b1);
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R10: reset state
        drive(0, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R10", "irq_pending", irq_pending, 0);
        chk("R10", "ppr", ppr, 0);
        tick();
        // R1: first request accepted, then offered
        drive(1, 'h45, 1, 0, 0, 0, 0, 1, 1);
        chk("R1", "accept 45", req_accepted, 1);
        tick();
        // R2: repeat is coalesced
        drive(1, 'h45, 0, 0, 0, 0, 0, 1, 1);
        chk("R2", "coalesce 45", req_accepted, 0);
        chk("R6", "offer 45", irq_vector, 'h45);
        tick();
        // R3: low vector and disabled unit both drop
        drive(1, 'h08, 0, 0, 0, 0, 0, 1, 1);
        chk("R3", "low vector", req_accepted, 0);
        tick();
        drive(1, 'h50, 0, 0, 0, 0, 0, 1, 0);
        chk("R3", "sw disabled", req_accepted, 0);
        tick();
        drive(0, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R3", "50 not offered", irq_vector, 'h45);
        tick();
        // R6/R9: task priority gate, effective next cycle
        step(0, 0, 0, 1, 'h50, 0, 0);
        drive(0, 0, 0, 1, 'h3F, 0, 0, 1, 1);
        chk("R6", "masked by tpr 50", irq_pending, 0);
        tick();
        drive(0, 0, 0, 0, 0, 1, 0, 1, 1);
        chk("R9", "tpr 3F seen", ppr, 'h3F);
        chk("R6", "40 above 3F", irq_pending, 1);
        tick();
        // R5/R7: after acknowledge ppr follows in-service class
        drive(1, 'h91, 0, 0, 0, 1, 0, 1, 1);
        chk("R5", "ppr from isr", ppr, 'h40);
        chk("R7", "ack without offer", irq_pending, 0);
        tick();
        // R9: acknowledge 91 and retire 45 in one cycle
        drive(0, 0, 0, 0, 0, 1, 1, 1, 1);
        chk("R9", "offer 91", irq_vector, 'h91);
        chk("R8", "retire 45", eoi_vector, 'h45);
        chk("R4", "45 level", eoi_level, 1);
        tick();
        drive(0, 0, 0, 0, 0, 0, 1, 1, 1);
        chk("R9", "ppr 90", ppr, 'h90);
        chk("R4", "91 edge", eoi_level, 0);
        tick();
        drive(0, 0, 0, 0, 0, 0, 1, 1, 1);
        chk("R8", "empty eoi", eoi_valid, 0);
        tick();
        // Random traffic compared against the model every clock
        for (int n = 0; n < 4000; n++) begin
            int v;
            v = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 15) : $urandom_range(16, 255);
            drive($urandom_range(0, 1), v, $urandom_range(0, 1),
                  $urandom_range(0, 9) == 0, $urandom_range(0, 255),
                  $urandom_range(0, 4) < 2, $urandom_range(0, 4) == 0,
                  $urandom_range(0, 19) != 0, $urandom_range(0, 19) != 0);
            tick();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule